// File: doc/BRIEF.md
# Domain Power Sequencer

This block controls one switchable power domain and the run state of a set of peripheral modules inside it. Software programs a requested next state for each module through a register array. It also sets a power request bit for the domain. A write to the command register then starts a domain transition. Module requests have no effect until that command arrives. When the transition completes, every module takes its requested state in the same cycle.

If the domain is unpowered and software asks for it to be on, the sequencer raises an external power request and flags a pending handshake. It then stalls. Software watches the external supply-good signal, which appears in the domain status register, and confirms with an acknowledge bit. Only after that acknowledge does the domain report powered and the module update continue. A fixed settle interval models the clock-stop and reset handshakes of the modules. When the domain is already on, a command only applies the module requests. A command whose latched power request is off powers the domain down as the modules update.

All registers are 32-bit words on a simple single-cycle write bus with a combinational read port.

Top module: `domain_power_sequencer`

## Requirements
- R1: After reset all module status fields read 0, the domain status bit 0 (powered) reads 0, the pending register (0x070) and the busy register (0x128) read 0, and `ext_pwr_req` is low.
- R2: A write to module control at 0xA00 + 4*n stores `bus_wdata[4:0]` as module n's next state, which reads back at the same address; module status at 0x800 + 4*n does not change on that write.
- R3: A write to 0x120 with bit `DOM_ID` (default 1) set, while idle and with no handshake needed, sets bit `DOM_ID` of 0x128 from the next cycle. Exactly `SETTLE_CYCLES` clock edges after the command edge, every module status takes its next state and the busy bit clears.
- R4: If the command arrives while the domain is off and domain control bit 0 (at 0x304) is 1, bit `DOM_ID` of 0x070 sets and `ext_pwr_req` rises on the next cycle. Both hold, with the domain off and module states unchanged, until an acknowledge.
- R5: While pending, a write to 0x304 with bit 8 set clears the pending bit and `ext_pwr_req` and sets domain status bit 0 on the next cycle. Module states update `SETTLE_CYCLES` edges after the acknowledge edge.
- R6: A command while the domain is already on never sets the pending bit or `ext_pwr_req`.
- R7: Commands written while a transition is in progress, including one in the completion cycle, are ignored. So is a write to 0x120 without bit `DOM_ID`. Neither moves the completion point nor starts a new transition.
- R8: If domain control bit 0 is 0 when the command is accepted, domain status bit 0 clears in the same cycle as the module update.
- R9: An acknowledge write (bit 8 of 0x304) with no handshake pending has no effect on the domain state, and bit 8 always reads 0.
- R10: Domain status bit 1 (0x200) shows the `ext_pwr_good` input.
- R11: A module control write during a transition is used at completion if it is written before the completion cycle. A write in the completion cycle itself waits for the next transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| ext_pwr_good | input | 1 | Supply-good from the external switch |
| ext_pwr_req | output | 1 | Request to the external switch to power the domain |

## Verification
Two functions can fall on the same clock edge: completion of a transition, and a register write that would feed it. The bench places a module control write on the completion edge, and separately a fresh command on that edge. It counts cycles from the command so that the write is sampled exactly when the settle counter expires. The write must not reach the status being applied, and the extra command must leave the sequencer idle. A behavioural model, kept with integers and a countdown, judges every read value and `ext_pwr_req` on every clock.

// File: rtl/dps_pkg.sv
package dps_pkg;

    localparam logic [11:0] OFS_PEND  = 12'h070;
    localparam logic [11:0] OFS_CMD   = 12'h120;
    localparam logic [11:0] OFS_BUSY  = 12'h128;
    localparam logic [11:0] OFS_DSTAT = 12'h200;
    localparam logic [11:0] OFS_DCTL  = 12'h304;
    localparam logic [11:0] OFS_MSTAT = 12'h800;
    localparam logic [11:0] OFS_MCTL  = 12'hA00;

    localparam int ST_W       = 5;
    localparam int ACK_BIT    = 8;
    localparam int ON_BIT     = 0;
    localparam int GOOD_BIT   = 1;

    typedef logic [ST_W-1:0] mstate_t;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_WAIT_PWR,
        SEQ_SETTLE
    } seq_t;

    typedef struct packed {
        logic cmd;
        logic dctl;
        logic ack;
        logic mctl;
    } wr_strobe_t;

    function automatic logic arr_hit(input logic [11:0] a, input logic [11:0] base, input int n);
        return (a[1:0] == 2'b00) &&
               (int'(a[11:2]) >= int'(base[11:2])) &&
               (int'(a[11:2]) <  int'(base[11:2]) + n);
    endfunction

    function automatic int arr_idx(input logic [11:0] a, input logic [11:0] base);
        return int'(a[11:2]) - int'(base[11:2]);
    endfunction

endpackage

// File: rtl/dps_bus_decode.sv
module dps_bus_decode
    import dps_pkg::*;
#(
    parameter int N_MOD  = 4,
    parameter int DOM_ID = 1,
    localparam int IDX_W = (N_MOD > 1) ? $clog2(N_MOD) : 1
) (
    input  logic             bus_wr,
    input  logic [11:0]      bus_addr,
    input  logic [31:0]      bus_wdata,
    output wr_strobe_t       stb,
    output logic [IDX_W-1:0] mod_idx
);

    always_comb begin
        stb      = '0;
        stb.cmd  = bus_wr && (bus_addr == OFS_CMD) && bus_wdata[DOM_ID];
        stb.dctl = bus_wr && (bus_addr == OFS_DCTL);
        stb.ack  = stb.dctl && bus_wdata[ACK_BIT];
        stb.mctl = bus_wr && arr_hit(bus_addr, OFS_MCTL, N_MOD);
        mod_idx  = IDX_W'(arr_idx(bus_addr, OFS_MCTL));
    end

endmodule

// File: rtl/dps_module_bank.sv
module dps_module_bank
    import dps_pkg::*;
#(
    parameter int N_MOD  = 4,
    localparam int IDX_W = (N_MOD > 1) ? $clog2(N_MOD) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  mstate_t                    wr_data,
    input  logic                       apply,
    output logic [N_MOD-1:0][ST_W-1:0] nxt,
    output logic [N_MOD-1:0][ST_W-1:0] cur
);

    for (genvar i = 0; i < N_MOD; i++) begin : g_mod
        always_ff @(posedge clk) begin
            if (rst) begin
                nxt[i] <= '0;
                cur[i] <= '0;
            end else begin
                if (apply)
                    cur[i] <= nxt[i];
                if (wr_en && (wr_idx == IDX_W'(i)))
                    nxt[i] <= wr_data;
            end
        end

        assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
            !apply |=> $stable(cur[i]));

        assert_apply_R3: assert property (@(posedge clk) disable iff (rst)
            apply |=> (cur[i] == $past(nxt[i])));
    end

endmodule

// File: rtl/dps_domain_seq.sv
module dps_domain_seq
    import dps_pkg::*;
#(
    parameter int SETTLE = 4,
    localparam int CNT_W = (SETTLE > 1) ? $clog2(SETTLE) : 1,
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE - 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic cmd,
    input  logic ack,
    input  logic req_on,
    output logic busy,
    output logic pending,
    output logic dom_on,
    output logic apply
);

    seq_t             state;
    logic [CNT_W-1:0] cnt;
    logic             tgt_on;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SEQ_IDLE;
            cnt     <= '0;
            pending <= 1'b0;
            dom_on  <= 1'b0;
            tgt_on  <= 1'b0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (cmd) begin
                        tgt_on <= req_on;
                        cnt    <= '0;
                        if (!dom_on && req_on) begin
                            state   <= SEQ_WAIT_PWR;
                            pending <= 1'b1;
                        end else begin
                            state <= SEQ_SETTLE;
                        end
                    end
                end
                SEQ_WAIT_PWR: begin
                    if (ack) begin
                        pending <= 1'b0;
                        dom_on  <= 1'b1;
                        cnt     <= '0;
                        state   <= SEQ_SETTLE;
                    end
                end
                SEQ_SETTLE: begin
                    if (cnt == LAST) begin
                        state <= SEQ_IDLE;
                        if (!tgt_on)
                            dom_on <= 1'b0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    assign busy  = (state != SEQ_IDLE);
    assign apply = (state == SEQ_SETTLE) && (cnt == LAST);

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (!busy && !pending && !dom_on));

    assert_start_R3: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_IDLE && cmd) |=> busy);

    assert_wait_R4: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_WAIT_PWR && !ack) |=> (pending && !dom_on && state == SEQ_WAIT_PWR));

    assert_ack_R5: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_WAIT_PWR && ack) |=> (dom_on && !pending && state == SEQ_SETTLE));

    assert_no_handshake_R6: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_IDLE && cmd && dom_on) |=> !pending);

    assert_no_restart_R7: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_SETTLE && cnt != LAST) |=> (state == SEQ_SETTLE && cnt == $past(cnt) + CNT_W'(1)));

    assert_power_down_R8: assert property (@(posedge clk) disable iff (rst)
        (apply && !tgt_on) |=> !dom_on);

endmodule

// File: rtl/domain_power_sequencer.sv
module domain_power_sequencer
    import dps_pkg::*;
#(
    parameter int N_MODULES     = 4,
    parameter int SETTLE_CYCLES = 4,
    parameter int DOM_ID        = 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic [11:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        ext_pwr_good,
    output logic        ext_pwr_req
);

    localparam int IDX_W = (N_MODULES > 1) ? $clog2(N_MODULES) : 1;

    wr_strobe_t                      stb;
    logic [IDX_W-1:0]                wr_idx;
    logic [N_MODULES-1:0][ST_W-1:0]  nxt;
    logic [N_MODULES-1:0][ST_W-1:0]  cur;
    logic                            busy, pending, dom_on, apply;
    logic                            ctl_on;
    logic [IDX_W-1:0]                rd_idx;

    dps_bus_decode #(.N_MOD(N_MODULES), .DOM_ID(DOM_ID)) i_dec (
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .stb      (stb),
        .mod_idx  (wr_idx)
    );

    dps_module_bank #(.N_MOD(N_MODULES)) i_bank (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (stb.mctl),
        .wr_idx (wr_idx),
        .wr_data(bus_wdata[ST_W-1:0]),
        .apply  (apply),
        .nxt    (nxt),
        .cur    (cur)
    );

    dps_domain_seq #(.SETTLE(SETTLE_CYCLES)) i_seq (
        .clk    (clk),
        .rst    (rst),
        .cmd    (stb.cmd),
        .ack    (stb.ack),
        .req_on (ctl_on),
        .busy   (busy),
        .pending(pending),
        .dom_on (dom_on),
        .apply  (apply)
    );

    always_ff @(posedge clk) begin
        if (rst)
            ctl_on <= 1'b0;
        else if (stb.dctl)
            ctl_on <= bus_wdata[ON_BIT];
    end

    assign ext_pwr_req = pending;

    always_comb begin
        bus_rdata = '0;
        rd_idx    = '0;
        if (bus_addr == OFS_PEND) begin
            bus_rdata[DOM_ID] = pending;
        end else if (bus_addr == OFS_BUSY) begin
            bus_rdata[DOM_ID] = busy;
        end else if (bus_addr == OFS_DSTAT) begin
            bus_rdata[ON_BIT]   = dom_on;
            bus_rdata[GOOD_BIT] = ext_pwr_good;
        end else if (bus_addr == OFS_DCTL) begin
            bus_rdata[ON_BIT] = ctl_on;
        end else if (arr_hit(bus_addr, OFS_MSTAT, N_MODULES)) begin
            rd_idx = IDX_W'(arr_idx(bus_addr, OFS_MSTAT));
            bus_rdata[ST_W-1:0] = cur[rd_idx];
        end else if (arr_hit(bus_addr, OFS_MCTL, N_MODULES)) begin
            rd_idx = IDX_W'(arr_idx(bus_addr, OFS_MCTL));
            bus_rdata[ST_W-1:0] = nxt[rd_idx];
        end
    end

    assert_pend_off_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(ext_pwr_req) |-> !dom_on);

    assert_ack_clears_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(ext_pwr_req) |-> dom_on);

    assert_stray_ack_R9: assert property (@(posedge clk) disable iff (rst)
        (stb.ack && !pending && !dom_on) |=> !dom_on);

endmodule

// File: tb/test_domain_power_sequencer.sv
module test_domain_power_sequencer;

    localparam int N   = 4;
    localparam int S   = 4;
    localparam int DOM = 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = 12'h000;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        ext_pwr_good = 1'b0;
    logic        ext_pwr_req;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    domain_power_sequencer #(.N_MODULES(N), .SETTLE_CYCLES(S), .DOM_ID(DOM)) i_domain_power_sequencer (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_pwr_good(ext_pwr_good), .ext_pwr_req(ext_pwr_req)
    );

    always #10 clk = ~clk;

    // behavioural reference model
    int m_next[N];
    int m_cur[N];
    bit m_on, m_pend, m_ctl, m_tgt, m_wait;
    int m_cd;

    always @(posedge clk) begin
        bit was_busy;
        if (rst) begin
            for (int i = 0; i < N; i++) begin m_next[i] = 0; m_cur[i] = 0; end
            m_on = 0; m_pend = 0; m_ctl = 0; m_tgt = 0; m_wait = 0; m_cd = 0;
        end else begin
            was_busy = m_wait || (m_cd > 0);
            if (m_cd > 0) begin
                m_cd--;
                if (m_cd == 0) begin
                    for (int i = 0; i < N; i++) m_cur[i] = m_next[i];
                    if (!m_tgt) m_on = 0;
                end
            end
            if (m_wait && bus_wr && bus_addr == 12'h304 && bus_wdata[8]) begin
                m_wait = 0; m_pend = 0; m_on = 1; m_cd = S;
            end
            if (!was_busy && bus_wr && bus_addr == 12'h120 && bus_wdata[DOM]) begin
                m_tgt = m_ctl;
                if (!m_on && m_ctl) begin m_wait = 1; m_pend = 1; end
                else m_cd = S;
            end
            if (bus_wr && bus_addr == 12'h304) m_ctl = bus_wdata[0];
            if (bus_wr && bus_addr[1:0] == 2'b00 && bus_addr >= 12'hA00 && bus_addr < 12'hA00 + 4*N)
                m_next[(bus_addr - 12'hA00) >> 2] = int'(bus_wdata[4:0]);
        end
    end

    function automatic logic [31:0] model_read(input logic [11:0] a);
        logic [31:0] v = '0;
        if (a == 12'h070) v[DOM] = m_pend;
        else if (a == 12'h128) v[DOM] = m_wait || (m_cd > 0);
        else if (a == 12'h200) begin v[0] = m_on; v[1] = ext_pwr_good; end
        else if (a == 12'h304) v[0] = m_ctl;
        else if (a[1:0] == 2'b00 && a >= 12'h800 && a < 12'h800 + 4*N) v = 32'(m_cur[(a - 12'h800) >> 2]);
        else if (a[1:0] == 2'b00 && a >= 12'hA00 && a < 12'hA00 + 4*N) v = 32'(m_next[(a - 12'hA00) >> 2]);
        return v;
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, got, exp);
        end
    endtask

    // lockstep comparison on every clock
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R3", "lockstep read", bus_rdata, model_read(bus_addr));
            chk("R4", "lockstep ext_pwr_req", {31'b0, ext_pwr_req}, {31'b0, m_pend});
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #2;
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic chk_rd(input string tag, input logic [11:0] a, input logic [31:0] exp);
        bus_addr = a; #1;
        chk(tag, $sformatf("read 0x%03h", a), bus_rdata, exp);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        step(3); rst = 1'b0; step(1);

        // R1: reset state
        chk_rd("R1", 12'h070, 0);
        chk_rd("R1", 12'h128, 0);
        chk_rd("R1", 12'h200, 0);
        for (int i = 0; i < N; i++) chk_rd("R1", 12'h800 + 12'(4*i), 0);
        chk("R1", "ext_pwr_req", {31'b0, ext_pwr_req}, 0);

        // R10: supply-good visible
        ext_pwr_good = 1'b1;
        chk_rd("R10", 12'h200, 32'h2);
        ext_pwr_good = 1'b0;
        chk_rd("R10", 12'h200, 32'h0);

        // R2: next states stored, status untouched
        wr(12'hA00, 3); wr(12'hA04, 3); wr(12'hA08, 2); wr(12'hA0C, 3);
        chk_rd("R2", 12'hA08, 2);
        chk_rd("R2", 12'hA0C, 3);
        chk_rd("R2", 12'h800, 0);

        // R9: stray acknowledge
        wr(12'h304, 32'h100);
        chk_rd("R9", 12'h200, 0);
        chk_rd("R9", 12'h304, 0);

        // R7: command without the domain bit
        wr(12'h120, 32'h1);
        chk_rd("R7", 12'h128, 0);

        // R4: power-up needs handshake
        wr(12'h304, 32'h1);
        wr(12'h120, 32'h2);
        chk_rd("R4", 12'h070, 32'h2);
        chk_rd("R4", 12'h128, 32'h2);
        chk("R4", "ext_pwr_req", {31'b0, ext_pwr_req}, 1);
        step(10);
        chk_rd("R4", 12'h800, 0);
        chk_rd("R4", 12'h200, 0);
        chk("R4", "ext_pwr_req held", {31'b0, ext_pwr_req}, 1);

        // R5: acknowledge then settle
        ext_pwr_good = 1'b1;
        wr(12'h304, 32'h101);
        chk_rd("R5", 12'h070, 0);
        chk("R5", "ext_pwr_req", {31'b0, ext_pwr_req}, 0);
        chk_rd("R5", 12'h200, 32'h3);
        chk_rd("R5", 12'h800, 0);
        step(S - 1);
        chk_rd("R5", 12'h128, 32'h2);
        chk_rd("R5", 12'h804, 0);
        step(1);
        chk_rd("R3", 12'h128, 0);
        chk_rd("R3", 12'h800, 3);
        chk_rd("R3", 12'h804, 3);
        chk_rd("R3", 12'h808, 2);
        chk_rd("R3", 12'h80C, 3);

        // R6 / R3 / R7: domain on, exact timing, ignored re-command
        wr(12'hA00, 2);
        wr(12'h120, 32'h2);
        chk_rd("R6", 12'h070, 0);
        chk("R6", "ext_pwr_req", {31'b0, ext_pwr_req}, 0);
        step(1);
        wr(12'h120, 32'h2);
        step(S - 3);
        chk_rd("R3", 12'h800, 3);
        chk_rd("R3", 12'h128, 32'h2);
        step(1);
        chk_rd("R3", 12'h800, 2);
        chk_rd("R7", 12'h128, 0);
        step(2);
        chk_rd("R7", 12'h128, 0);

        // R11: module writes during a transition
        wr(12'hA04, 2);
        wr(12'h120, 32'h2);
        step(1);
        wr(12'hA08, 3);
        step(S - 3);
        wr(12'hA0C, 2);
        chk_rd("R11", 12'h804, 2);
        chk_rd("R11", 12'h808, 3);
        chk_rd("R11", 12'h80C, 3);
        chk_rd("R11", 12'hA0C, 2);

        // R7: command landing on the completion edge
        wr(12'h120, 32'h2);
        step(S - 1);
        wr(12'h120, 32'h2);
        chk_rd("R7", 12'h128, 0);
        chk_rd("R11", 12'h80C, 2);

        // R8: power down
        wr(12'h304, 32'h0);
        wr(12'h120, 32'h2);
        step(S - 1);
        chk_rd("R8", 12'h200, 32'h3);
        step(1);
        chk_rd("R8", 12'h200, 32'h2);
        chk_rd("R8", 12'h128, 0);

        // R4 / R5 again after power-down
        wr(12'h304, 32'h1);
        wr(12'h120, 32'h2);
        chk_rd("R4", 12'h070, 32'h2);
        wr(12'h304, 32'h101);
        step(S);
        chk_rd("R5", 12'h200, 32'h3);
        chk_rd("R5", 12'h128, 0);

        step(2);
        finish_run();
    end

endmodule